// File: doc/BRIEF.md
# Four-multiplier add/subtract/sum DSP slice

The slice multiplies four operand pairs, combines the products in two pairs through add/subtract units and adds the two pair results into one wide sum. One control picks two's-complement or unsigned arithmetic for all four multipliers. Each pair unit has its own add-or-subtract control. Every control travels through the same registers as the data it belongs to, so a mode change takes effect on exactly the operands presented with it.

The datapath has three register groups: input, pipeline and output. Each group can be left out by a parameter, and each one takes its clock enable and its synchronous clear from one of four shared lanes, chosen by parameter. The A and B input registers can also form a shift chain, lane by lane, so that operands cascade from a neighbouring slice. Operands narrower than the native width are widened by the user: zero fill for unsigned, sign extension for signed. A global asynchronous active-low reset is released through a two-flop synchroniser.

Top module: `dsp_quad_mac`

## Requirements
- R1: While `rst_n` is low, `sum_out`, `a_cas_out` and `b_cas_out` are all zero.
- R2: `sum_out` equals (P0 op0 P1) + (P2 op1 P3) as an A_W+B_W+2-bit two's-complement value, where Pk = Ak×Bk. Lane k of `a_in`/`b_in` occupies bits [k*W +: W]. When `signed_mode`=1 the operands are two's complement; when it is 0 they are unsigned. `sub0`=1 makes op0 a subtraction and 0 makes it an addition; `sub1` does the same for op1.
- R3: A 9-bit operand extended to 18 bits (sign extension when `signed_mode`=1, zero fill when 0) gives the exact 9-bit product.
- R4: With all three stages present, a vector and its control bits appear at `sum_out` three clock edges after they are applied. Control changes from one cycle to the next apply only to their own vector.
- R5: A stage updates only in a cycle where its selected bit of `ce_lane` is 1; otherwise it holds. The defaults are input = lane 0, pipeline = lane 1, output = lane 2.
- R6: A stage whose selected bit of `srst_lane` is 1 clears to zero at the next edge, whatever its clock enable. The defaults use the same lanes as in R5.
- R7: A lane whose bit is set in A_SHIFT (or B_SHIFT) loads its input register from the previous lane's register; lane 0 loads from `a_cas_in`/`b_cas_in`. `a_cas_out`/`b_cas_out` show the lane-3 register.
- R8: When PIPE_REG=0 the pipeline stage is a wire, and the latency falls to two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_lane | input | 4 | Clock-enable lanes, bit k = lane k |
| srst_lane | input | 4 | Synchronous clear lanes, active high, bit k = lane k |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| sub0 | input | 1 | Pair 0 (P0,P1): 1 = subtract, 0 = add |
| sub1 | input | 1 | Pair 1 (P2,P3): 1 = subtract, 0 = add |
| a_in | input | 4*A_W | Multiplicands, lane k at [k*A_W +: A_W] |
| b_in | input | 4*B_W | Multipliers, lane k at [k*B_W +: B_W] |
| a_cas_in | input | A_W | A shift-chain input to lane 0 |
| b_cas_in | input | B_W | B shift-chain input to lane 0 |
| a_cas_out | output | A_W | Lane-3 A register |
| b_cas_out | output | B_W | Lane-3 B register |
| sum_out | output | A_W+B_W+2 | Final sum |

## Verification
The bench builds two copies. The first, `u0`, uses the default 18-bit operands, all three stages and the lane choices 0/1/2. With it, the bench can check full-range signed and unsigned products, unsigned subtraction that goes negative, per-cycle mode changes in a back-to-back stream, and gating or clearing of single stages through their own lanes. The second, `u1`, sets every lane to the shift chain and leaves out the pipeline stage. This makes the cascade order at the lane-3 port and the shortened two-edge latency observable.

// File: rtl/dsp_quad_pkg.sv
package dsp_quad_pkg;
  parameter int unsigned NUM_MULT = 4;
  parameter int unsigned NUM_LANE = 4;
  parameter int unsigned CTL_W    = 3;   // {signed, sub1, sub0}
  typedef logic [NUM_LANE-1:0] lane_vec_t;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  assign sync_nxt = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsp_stage_reg.sv
module dsp_stage_reg
  import dsp_quad_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter bit          REG_EN  = 1'b1,
  parameter int unsigned CE_SEL  = 0,
  parameter int unsigned RST_SEL = 0
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  lane_vec_t      ce_lane,
  input  lane_vec_t      srst_lane,
  input  logic [W-1:0]   d,
  output logic [W-1:0]   q
);
  if (REG_EN) begin : g_reg
    logic         ce;
    logic         srst;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;
    logic         unused_lanes;

    assign ce           = ce_lane[CE_SEL];
    assign srst         = srst_lane[RST_SEL];
    assign unused_lanes = ^{ce_lane, srst_lane};

    always_comb begin
      q_nxt = q_r;
      if (srst)    q_nxt = '0;
      else if (ce) q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= q_nxt;
    end

    assign q = q_r;

    // R5
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (!srst && !ce) |=> $stable(q_r));
    // R6
    stage_srst_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      srst |=> (q_r == '0));
  end else begin : g_thru
    logic unused_thru;
    assign unused_thru = ^{clk, rst_ni, ce_lane, srst_lane};
    assign q = d;
  end
endmodule

// File: rtl/dsp_mult.sv
module dsp_mult #(
  parameter int unsigned AW = 18,
  parameter int unsigned BW = 18
) (
  input  logic              signed_mode,
  input  logic [AW-1:0]     a,
  input  logic [BW-1:0]     b,
  output logic [AW+BW-1:0]  p
);
  localparam int unsigned PW = AW + BW;

  logic signed [AW:0]   a_x;
  logic signed [BW:0]   b_x;
  logic signed [PW+1:0] full;
  logic                 unused_hi;

  assign a_x       = {signed_mode & a[AW-1], a};
  assign b_x       = {signed_mode & b[BW-1], b};
  assign full      = a_x * b_x;
  assign p         = full[PW-1:0];
  assign unused_hi = ^full[PW+1:PW];
endmodule

// File: rtl/dsp_addsub.sv
module dsp_addsub #(
  parameter int unsigned IW = 36
) (
  input  logic          sub,
  input  logic          ext_x,
  input  logic          ext_y,
  input  logic [IW-1:0] x,
  input  logic [IW-1:0] y,
  output logic [IW:0]   r
);
  logic [IW:0] xw;
  logic [IW:0] yw;

  assign xw = {ext_x & x[IW-1], x};
  assign yw = {ext_y & y[IW-1], y};
  assign r  = sub ? (xw - yw) : (xw + yw);
endmodule

// File: rtl/dsp_quad_mac.sv
module dsp_quad_mac
  import dsp_quad_pkg::*;
#(
  parameter int unsigned A_W          = 18,
  parameter int unsigned B_W          = 18,
  parameter bit          IN_REG       = 1'b1,
  parameter bit          PIPE_REG     = 1'b1,
  parameter bit          OUT_REG      = 1'b1,
  parameter int unsigned IN_CE_SEL    = 0,
  parameter int unsigned IN_RST_SEL   = 0,
  parameter int unsigned PIPE_CE_SEL  = 1,
  parameter int unsigned PIPE_RST_SEL = 1,
  parameter int unsigned OUT_CE_SEL   = 2,
  parameter int unsigned OUT_RST_SEL  = 2,
  parameter logic [NUM_MULT-1:0] A_SHIFT = '0,
  parameter logic [NUM_MULT-1:0] B_SHIFT = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LANE-1:0]     ce_lane,
  input  logic [NUM_LANE-1:0]     srst_lane,
  input  logic                    signed_mode,
  input  logic                    sub0,
  input  logic                    sub1,
  input  logic [NUM_MULT*A_W-1:0] a_in,
  input  logic [NUM_MULT*B_W-1:0] b_in,
  input  logic [A_W-1:0]          a_cas_in,
  input  logic [B_W-1:0]          b_cas_in,
  output logic [A_W-1:0]          a_cas_out,
  output logic [B_W-1:0]          b_cas_out,
  output logic [A_W+B_W+1:0]      sum_out
);
  localparam int unsigned PW     = A_W + B_W;
  localparam int unsigned SW     = PW + 2;
  localparam int unsigned PIPE_W = NUM_MULT * PW + CTL_W;

  logic                   rst_ni;
  logic [A_W-1:0]         a_q  [NUM_MULT];
  logic [B_W-1:0]         b_q  [NUM_MULT];
  logic [PW-1:0]          prod [NUM_MULT];
  logic [PW-1:0]          pp   [NUM_MULT];
  logic [NUM_MULT*PW-1:0] prod_v;
  logic [CTL_W-1:0]       ctl_d, ctl_q, ctl_p;
  logic [PIPE_W-1:0]      pipe_q;
  logic [PW:0]            pair0, pair1;
  logic [SW-1:0]          sum_c;

  dsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  // Input stage: operands per lane, shift-chain source selected per lane
  for (genvar i = 0; i < NUM_MULT; i++) begin : g_lane
    logic [A_W-1:0] a_src, a_d;
    logic [B_W-1:0] b_src, b_d;

    if (i == 0) begin : g_head
      assign a_src = a_cas_in;
      assign b_src = b_cas_in;
    end else begin : g_link
      assign a_src = a_q[i-1];
      assign b_src = b_q[i-1];
    end

    assign a_d = A_SHIFT[i] ? a_src : a_in[i*A_W +: A_W];
    assign b_d = B_SHIFT[i] ? b_src : b_in[i*B_W +: B_W];

    dsp_stage_reg #(.W(A_W), .REG_EN(IN_REG), .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)) u_a (
      .clk(clk), .rst_ni(rst_ni), .ce_lane(ce_lane), .srst_lane(srst_lane), .d(a_d), .q(a_q[i])
    );
    dsp_stage_reg #(.W(B_W), .REG_EN(IN_REG), .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)) u_b (
      .clk(clk), .rst_ni(rst_ni), .ce_lane(ce_lane), .srst_lane(srst_lane), .d(b_d), .q(b_q[i])
    );

    dsp_mult #(.AW(A_W), .BW(B_W)) u_mul (
      .signed_mode(ctl_q[2]), .a(a_q[i]), .b(b_q[i]), .p(prod[i])
    );

    assign prod_v[i*PW +: PW] = prod[i];
    assign pp[i]              = pipe_q[i*PW +: PW];

    if (i > 0 && IN_REG) begin : g_chain_chk
      // R7
      a_shift_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (A_SHIFT[i] && ce_lane[IN_CE_SEL] && !srst_lane[IN_RST_SEL])
          |=> (a_q[i] == $past(a_q[i-1])));
    end
  end

  assign ctl_d = {signed_mode, sub1, sub0};

  dsp_stage_reg #(.W(CTL_W), .REG_EN(IN_REG), .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)) u_ctl_in (
    .clk(clk), .rst_ni(rst_ni), .ce_lane(ce_lane), .srst_lane(srst_lane), .d(ctl_d), .q(ctl_q)
  );

  // Pipeline stage: products and their controls
  dsp_stage_reg #(.W(PIPE_W), .REG_EN(PIPE_REG), .CE_SEL(PIPE_CE_SEL), .RST_SEL(PIPE_RST_SEL)) u_pipe (
    .clk(clk), .rst_ni(rst_ni), .ce_lane(ce_lane), .srst_lane(srst_lane),
    .d({ctl_q, prod_v}), .q(pipe_q)
  );

  assign ctl_p = pipe_q[NUM_MULT*PW +: CTL_W];

  dsp_addsub #(.IW(PW)) u_pair0 (
    .sub(ctl_p[0]), .ext_x(ctl_p[2]), .ext_y(ctl_p[2]), .x(pp[0]), .y(pp[1]), .r(pair0)
  );
  dsp_addsub #(.IW(PW)) u_pair1 (
    .sub(ctl_p[1]), .ext_x(ctl_p[2]), .ext_y(ctl_p[2]), .x(pp[2]), .y(pp[3]), .r(pair1)
  );
  // A pair result is signed when operands are signed or its unit subtracted
  dsp_addsub #(.IW(PW+1)) u_total (
    .sub(1'b0), .ext_x(ctl_p[2] | ctl_p[0]), .ext_y(ctl_p[2] | ctl_p[1]),
    .x(pair0), .y(pair1), .r(sum_c)
  );

  // Output stage
  dsp_stage_reg #(.W(SW), .REG_EN(OUT_REG), .CE_SEL(OUT_CE_SEL), .RST_SEL(OUT_RST_SEL)) u_out (
    .clk(clk), .rst_ni(rst_ni), .ce_lane(ce_lane), .srst_lane(srst_lane), .d(sum_c), .q(sum_out)
  );

  assign a_cas_out = a_q[NUM_MULT-1];
  assign b_cas_out = b_q[NUM_MULT-1];

  // R2
  prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_q[2] && a_q[0] != '0 && b_q[0] != '0)
      |-> (prod[0][PW-1] == (a_q[0][A_W-1] ^ b_q[0][B_W-1])));
  // R2
  sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_p[0] && pp[0] == pp[1]) |-> (pair0 == '0));
endmodule

// File: tb/sim_dsp_quad_mac.sv
`timescale 1ns/1ps
module sim_dsp_quad_mac;
  localparam int AW = 18;
  localparam int BW = 18;
  localparam int SW = AW + BW + 2;
  localparam int VW = 3 + 8 * 18;
  localparam int NV = 6;

  // {signed, sub0, sub1, a0, a1, a2, a3, b0, b1, b2, b3}
  localparam logic [VW-1:0] TBL [NV] = '{
    {1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF,
                       18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF},
    {1'b1, 1'b0, 1'b0, 18'h20000, 18'h20000, 18'h20000, 18'h20000,
                       18'h20000, 18'h20000, 18'h20000, 18'h20000},
    {1'b1, 1'b1, 1'b1, 18'd5, 18'd3, 18'h3FF9C, 18'd11,
                       18'd7, 18'h3FFFE, 18'd9, 18'h3FFF3},
    {1'b0, 1'b1, 1'b1, 18'd1, 18'h3FFFF, 18'd0, 18'h3FFFF,
                       18'd1, 18'h3FFFF, 18'd0, 18'd2},
    {1'b1, 1'b1, 1'b0, 18'h1FFFF, 18'h20000, 18'h1FFFF, 18'h20000,
                       18'h20000, 18'h1FFFF, 18'h1FFFF, 18'h20000},
    {1'b0, 1'b0, 1'b1, 18'd0, 18'd0, 18'd0, 18'd0,
                       18'd0, 18'd0, 18'd0, 18'd0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [3:0]    ce_lane, srst_lane;
  logic          sgn, sub0, sub1;
  logic [4*AW-1:0] a_in;
  logic [4*BW-1:0] b_in;
  logic [AW-1:0] a_cas_in, u0_aco, u1_aco;
  logic [BW-1:0] b_cas_in, u0_bco, u1_bco;
  logic [SW-1:0] u0_sum, u1_sum;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [SW-1:0] e1, e2, e3;
  bit v1, v2, v3;

  dsp_quad_mac u0 (
    .clk(clk), .rst_n(rst_n), .ce_lane(ce_lane), .srst_lane(srst_lane),
    .signed_mode(sgn), .sub0(sub0), .sub1(sub1), .a_in(a_in), .b_in(b_in),
    .a_cas_in(a_cas_in), .b_cas_in(b_cas_in),
    .a_cas_out(u0_aco), .b_cas_out(u0_bco), .sum_out(u0_sum)
  );

  dsp_quad_mac #(.PIPE_REG(1'b0), .A_SHIFT(4'hF), .B_SHIFT(4'hF)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_lane(ce_lane), .srst_lane(srst_lane),
    .signed_mode(sgn), .sub0(sub0), .sub1(sub1), .a_in('0), .b_in('0),
    .a_cas_in(a_cas_in), .b_cas_in(b_cas_in),
    .a_cas_out(u1_aco), .b_cas_out(u1_bco), .sum_out(u1_sum)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_sum(input logic [AW-1:0] a [4], input logic [BW-1:0] b [4],
                                            input logic g, input logic x0, input logic x1);
    longint p [4];
    longint pr0, pr1;
    logic [63:0] t;
    for (int i = 0; i < 4; i++) begin
      longint va, vb;
      va = g ? longint'($signed(a[i])) : longint'(a[i]);
      vb = g ? longint'($signed(b[i])) : longint'(b[i]);
      p[i] = va * vb;
    end
    pr0 = x0 ? p[0] - p[1] : p[0] + p[1];
    pr1 = x1 ? p[2] - p[3] : p[2] + p[3];
    t = pr0 + pr1;
    return t[SW-1:0];
  endfunction

  task automatic drive(input logic [AW-1:0] a [4], input logic [BW-1:0] b [4],
                       input logic g, input logic x0, input logic x1);
    for (int i = 0; i < 4; i++) begin
      a_in[i*AW +: AW] = a[i];
      b_in[i*BW +: BW] = b[i];
    end
    sgn = g; sub0 = x0; sub1 = x1;
  endtask

  // One vector per cycle; u0 output is compared three edges later (R4)
  task automatic step(input logic [AW-1:0] a [4], input logic [BW-1:0] b [4],
                      input logic g, input logic x0, input logic x1, input string req);
    @(negedge clk);
    if (v3) check(req, u0_sum, e3);
    e3 = e2; v3 = v2; e2 = e1; v2 = v1;
    drive(a, b, g, x0, x1);
    e1 = ref_sum(a, b, g, x0, x1);
    v1 = 1;
  endtask

  task automatic drain(input string req);
    repeat (3) begin
      @(negedge clk);
      if (v3) check(req, u0_sum, e3);
      e3 = e2; v3 = v2; e2 = e1; v2 = v1; v1 = 0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a [4];
    logic [BW-1:0] b [4];
    logic [AW-1:0] xa [4];
    logic [BW-1:0] xb [4];
    logic [AW-1:0] ya [4];
    logic [BW-1:0] yb [4];
    logic [AW-1:0] sa [4];
    logic [BW-1:0] sb [4];
    logic [SW-1:0] ex, ey;

    rst_n = 0; ce_lane = 4'hF; srst_lane = 4'h0;
    sgn = 1; sub0 = 1; sub1 = 0;
    a_in = '1; b_in = '1; a_cas_in = 18'h155; b_cas_in = 18'h2AA;
    v1 = 0; v2 = 0; v3 = 0; e1 = '0; e2 = '0; e3 = '0;

    // R1: outputs cleared while reset is held, inputs active
    repeat (3) @(negedge clk);
    check("R1", u0_sum, 0);
    check("R1", u0_aco, 0);
    check("R1", u0_bco, 0);
    check("R1", u1_sum, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2: table of corner vectors, streamed back to back
    for (int k = 0; k < NV; k++) begin
      a[0] = TBL[k][143:126]; a[1] = TBL[k][125:108];
      a[2] = TBL[k][107:90];  a[3] = TBL[k][89:72];
      b[0] = TBL[k][71:54];   b[1] = TBL[k][53:36];
      b[2] = TBL[k][35:18];   b[3] = TBL[k][17:0];
      step(a, b, TBL[k][146], TBL[k][145], TBL[k][144], "R2");
    end
    drain("R2");

    // R4: random full-width operands, modes change every cycle
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 4; i++) begin
        a[i] = 18'($urandom);
        b[i] = 18'($urandom);
      end
      step(a, b, 1'($urandom), 1'($urandom), 1'($urandom), "R4");
    end
    drain("R4");

    // R3: random 9-bit operands widened by sign extension or zero fill
    for (int k = 0; k < 40; k++) begin
      logic g;
      g = 1'($urandom);
      for (int i = 0; i < 4; i++) begin
        logic [8:0] ra, rb;
        ra = 9'($urandom);
        rb = 9'($urandom);
        a[i] = g ? {{9{ra[8]}}, ra} : {9'b0, ra};
        b[i] = g ? {{9{rb[8]}}, rb} : {9'b0, rb};
      end
      step(a, b, g, 1'($urandom), 1'($urandom), "R3");
    end
    drain("R3");

    // R5: output lane gated holds its value
    for (int i = 0; i < 4; i++) begin
      xa[i] = 18'(1000 + 77 * i); xb[i] = 18'(3 + 500 * i);
      ya[i] = 18'h3FF00 + 18'(i); yb[i] = 18'(2 + i);
    end
    ex = ref_sum(xa, xb, 1'b0, 1'b0, 1'b1);
    ey = ref_sum(ya, yb, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    drive(xa, xb, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R5", u0_sum, ex);
    ce_lane[2] = 1'b0;
    drive(ya, yb, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check("R5", u0_sum, ex);
    ce_lane[2] = 1'b1;
    @(negedge clk);
    check("R5", u0_sum, ey);

    // R6: pipeline clear on its own lane beats a low clock enable
    srst_lane[1] = 1'b1; ce_lane[1] = 1'b0;
    @(negedge clk);
    srst_lane[1] = 1'b0;
    check("R6", u0_sum, ey);
    @(negedge clk);
    check("R6", u0_sum, 0);
    ce_lane[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", u0_sum, ey);

    // R7 / R8: shift chain fill on u1, then freeze the input stage
    sgn = 1; sub0 = 0; sub1 = 1;
    for (int k = 0; k < 4; k++) begin
      sa[k] = 18'h3FFF0 + 18'(3 * k);
      sb[k] = 18'(1000 * (k + 1));
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a_cas_in = sa[k]; b_cas_in = sb[k];
    end
    @(negedge clk);
    ce_lane[0] = 1'b0;
    check("R7", u1_aco, sa[0]);
    for (int i = 0; i < 4; i++) begin
      a[i] = sa[3-i]; b[i] = sb[3-i];
    end
    @(negedge clk);
    check("R8", u1_sum, ref_sum(a, b, 1'b1, 1'b0, 1'b1));
    check("R7", u1_aco, sa[0]);
    check("R7", u1_bco, sb[0]);
    ce_lane[0] = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule